// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block takes a pair of 24-bit two's-complement samples (left and right) and sends them out on one serial data line, framed by a bit clock and a frame (word-select) clock. Each channel occupies a 32-slot half-frame. The data word goes out most significant bit first, and the slots left over after the least significant bit are driven low. Two framings are available. In the justified framing, the frame clock is high for the left channel and the first data bit sits in the first slot of the half. In the I2S framing, the frame clock is low for the left channel and the first data bit comes one slot after the frame clock edge.

The whole block runs on the master clock. When the clock-master select is high, the block divides the master clock into a bit clock of 64 slots per frame and a frame clock at the sample rate. The ratio select sets the number of master-clock cycles per frame. When the select is low, the block takes both clocks from outside. It passes them through two-flop synchronizers and follows their falling edges.

The producer writes a sample pair with a single-cycle load strobe. The pair is copied into the outgoing frame only at the start of the left half. If no new load arrives, the last pair is sent again.

Top module: `audio_tx_port`

## Requirements
- R1: While reset is asserted, and until the first bit-clock falling edge after it, the serial data, bit-clock output and frame-clock output are all low.
- R2: Each half-frame carries one 24-bit word, most significant bit first. The 8 slots that follow the least significant bit (or that surround the word in the I2S framing) are low.
- R3: In clock-master mode, the serial data changes only in the master-clock cycle in which the bit-clock output falls.
- R4: In clock-master mode, the bit clock is low for half of each bit period and high for the other half. The frame clock toggles once every 32 bit-clock falling edges, together with a falling edge.
- R5: In clock-master mode, the number of master-clock cycles per frame is set by ratio_sel: 2'b00 gives 256, 2'b01 gives 128, 2'b10 gives 512 and 2'b11 gives 384. This is 4, 2, 8 and 6 cycles per bit.
- R6: With fmt_i2s low, the frame clock is high during the left half. Word bit 23 is in slot 0 of the half and bit 0 is in slot 23.
- R7: With fmt_i2s high, the frame clock is low during the left half. Slot 0 of the half is low, word bit 23 is in slot 1 and bit 0 is in slot 24.
- R8: With master_sel high, bclk_out and lrclk_out are generated. With it low, both stay low and the timing follows bclk_in and lrclk_in.
- R9: In slave mode, each bclk_in falling edge advances one slot. The first falling edge after an lrclk_in change is slot 0 of a new half, and the lrclk_in level selects the channel as in R6/R7. Through the two-stage synchronizers, sdata changes on the third master-clock edge after the bclk_in fall and not on the second.
- R10: The pair is copied into the outgoing frame only at slot 0 of the left half. A frame without a load in between repeats the previous pair.
- R11: A load pulse captures left_in and right_in. The last load before a frame start is the one sent. A load in the same cycle as the frame start is kept for the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | High: generate clocks; low: follow external clocks |
| fmt_i2s | input | 1 | High: I2S framing; low: justified framing |
| ratio_sel | input | 2 | Master-clock cycles per frame in clock-master mode |
| load | input | 1 | One-cycle strobe capturing a new sample pair |
| left_in | input | 24 | Left-channel sample, two's complement |
| right_in | input | 24 | Right-channel sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| sdata | output | 1 | Serial sample data |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated frame clock (master mode) |

## Verification
The bench builds the block with its defaults: 24 data bits, 32-slot halves and two synchronizer stages. With these values, all four division ratios run in both framings, including the odd three-cycle half-period of the 384 ratio and the longest frame of 512 cycles. The 8 trailing slots appear in every half. A reference model follows each master-mode cycle and the bench compares all three outputs with it every clock, across reloaded, doubly loaded and skipped-load frames. Slave mode is driven with slow external clocks, and each bit is checked at the exact synchronizer depth.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int CPB_W        = 4;   // width of the per-bit cycle counter
    localparam int MAX_HALF_CYC = 4;   // longest bit-clock half period (512 ratio)

    typedef enum logic [1:0] {
        RATIO_256 = 2'b00,
        RATIO_128 = 2'b01,
        RATIO_512 = 2'b10,
        RATIO_384 = 2'b11
    } ratio_e;

    // master-clock cycles per serial bit: frame ratio divided by 64 slots
    function automatic logic [CPB_W-1:0] cycles_per_bit(input logic [1:0] sel);
        case (ratio_e'(sel))
            RATIO_256: return CPB_W'(4);
            RATIO_128: return CPB_W'(2);
            RATIO_512: return CPB_W'(8);
            default:   return CPB_W'(6);
        endcase
    endfunction

endpackage

// File: rtl/audio_tx_clkgen.sv
module audio_tx_clkgen
    import audio_tx_pkg::*;
#(
    parameter  int SLOT_W = 32,
    localparam int SCW    = $clog2(2 * SLOT_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           fmt_i2s,
    input  logic [1:0]     ratio_sel,
    output logic           tick,
    output logic [SCW-1:0] slot_next,
    output logic           bclk,
    output logic           lrclk
);

    typedef struct packed {
        logic [CPB_W-1:0] cyc;
        logic [SCW-1:0]   slot;
        logic             bclk;
        logic             lrclk;
    } gen_t;

    localparam gen_t GEN_RST = '{cyc: '0, slot: '1, bclk: 1'b0, lrclk: 1'b0};

    gen_t             gen_d, gen_q;
    logic [CPB_W-1:0] cpb;

    always_comb begin
        gen_d = gen_q;
        tick  = 1'b0;
        cpb   = cycles_per_bit(ratio_sel);
        if (gen_q.cyc >= cpb - CPB_W'(1)) begin
            gen_d.cyc   = '0;
            gen_d.slot  = gen_q.slot + SCW'(1);
            // left half is the first half of the frame; level depends on framing
            gen_d.lrclk = ~gen_d.slot[SCW-1] ^ fmt_i2s;
            tick        = en;
        end else begin
            gen_d.cyc = gen_q.cyc + CPB_W'(1);
        end
        gen_d.bclk = (gen_d.cyc >= (cpb >> 1));
        if (!en) begin
            gen_d = GEN_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= GEN_RST;
        else        gen_q <= gen_d;
    end

    assign slot_next = gen_d.slot;
    assign bclk      = gen_q.bclk;
    assign lrclk     = gen_q.lrclk;

endmodule

// File: rtl/audio_tx_slave_rx.sv
module audio_tx_slave_rx #(
    parameter int SYNC_STAGES = 2,   // must be 2 or more
    parameter int HW          = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bclk_in,
    input  logic          lrclk_in,
    output logic          tick,
    output logic [HW-1:0] pos,
    output logic          lr
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] bs;
        logic [SYNC_STAGES-1:0] ls;
        logic                   bprev;
        logic                   lr_last;
        logic [HW-1:0]          h;
    } rx_t;

    localparam rx_t RX_RST = '{bs: '0, ls: '0, bprev: 1'b0, lr_last: 1'b0, h: '1};

    rx_t  rx_d, rx_q;
    logic fall;

    always_comb begin
        rx_d       = rx_q;
        rx_d.bs    = {rx_q.bs[SYNC_STAGES-2:0], bclk_in};
        rx_d.ls    = {rx_q.ls[SYNC_STAGES-2:0], lrclk_in};
        rx_d.bprev = rx_q.bs[SYNC_STAGES-1];
        fall       = rx_q.bprev & ~rx_q.bs[SYNC_STAGES-1];
        if (fall) begin
            if (rx_q.ls[SYNC_STAGES-1] != rx_q.lr_last) rx_d.h = '0;
            else if (rx_q.h != '1)                      rx_d.h = rx_q.h + HW'(1);
            rx_d.lr_last = rx_q.ls[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= RX_RST;
        else        rx_q <= rx_d;
    end

    assign tick = fall & en;
    assign pos  = rx_d.h;
    assign lr   = rx_q.ls[SYNC_STAGES-1];

endmodule

// File: rtl/audio_tx_shifter.sv
module audio_tx_shifter #(
    parameter int DATA_W = 24,
    parameter int HW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              left,
    input  logic [HW-1:0]     pos,
    input  logic              fmt_i2s,
    input  logic              load,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic              sdata
);

    localparam int IW = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] hold_l;
        logic [DATA_W-1:0] hold_r;
        logic [DATA_W-1:0] pair_l;
        logic [DATA_W-1:0] pair_r;
        logic              sd;
    } sh_t;

    sh_t               sh_d, sh_q;
    logic [DATA_W-1:0] word;
    logic [IW-1:0]     idx;
    int                p;

    always_comb begin
        sh_d = sh_q;
        word = '0;
        idx  = '0;
        p    = 0;
        if (tick) begin
            if (left && pos == '0) begin
                sh_d.pair_l = sh_q.hold_l;
                sh_d.pair_r = sh_q.hold_r;
            end
            word    = left ? sh_d.pair_l : sh_d.pair_r;
            p       = int'(pos) - (fmt_i2s ? 1 : 0);
            sh_d.sd = 1'b0;
            if (p >= 0 && p < DATA_W) begin
                idx     = IW'(DATA_W - 1 - p);
                sh_d.sd = word[idx];
            end
        end
        if (load) begin
            sh_d.hold_l = left_in;
            sh_d.hold_r = right_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdata = sh_q.sd;

endmodule

// File: rtl/audio_tx_port.sv
module audio_tx_port #(
    parameter  int DATA_W      = 24,
    parameter  int SLOT_W      = 32,
    parameter  int SYNC_STAGES = 2,
    localparam int HW          = $clog2(SLOT_W),
    localparam int SCW         = HW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              fmt_i2s,
    input  logic [1:0]        ratio_sel,
    input  logic              load,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    output logic              sdata,
    output logic              bclk_out,
    output logic              lrclk_out
);

    logic           m_tick, s_tick, s_lr, tick, left;
    logic [SCW-1:0] m_slot;
    logic [HW-1:0]  s_pos, pos;

    audio_tx_clkgen #(.SLOT_W(SLOT_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (master_sel),
        .fmt_i2s   (fmt_i2s),
        .ratio_sel (ratio_sel),
        .tick      (m_tick),
        .slot_next (m_slot),
        .bclk      (bclk_out),
        .lrclk     (lrclk_out)
    );

    audio_tx_slave_rx #(.SYNC_STAGES(SYNC_STAGES), .HW(HW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (~master_sel),
        .bclk_in  (bclk_in),
        .lrclk_in (lrclk_in),
        .tick     (s_tick),
        .pos      (s_pos),
        .lr       (s_lr)
    );

    // select the slot source: own divider or synchronized external clocks
    assign tick = master_sel ? m_tick : s_tick;
    assign pos  = master_sel ? m_slot[HW-1:0] : s_pos;
    assign left = master_sel ? ~m_slot[SCW-1] : (s_lr ^ fmt_i2s);

    audio_tx_shifter #(.DATA_W(DATA_W), .HW(HW)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .left     (left),
        .pos      (pos),
        .fmt_i2s  (fmt_i2s),
        .load     (load),
        .left_in  (left_in),
        .right_in (right_in),
        .sdata    (sdata)
    );

endmodule

// File: rtl/audio_tx_port_chk.sv
module audio_tx_port_chk
    import audio_tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic master_sel,
    input logic sdata,
    input logic bclk_out,
    input logic lrclk_out
);

    logic       prev_b, prev_lr, seen, lr_chg;
    logic [3:0] run;
    logic [7:0] fcnt;

    assign lr_chg = prev_lr != lrclk_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !master_sel) begin
            prev_b  <= 1'b0;
            prev_lr <= 1'b0;
            seen    <= 1'b0;
            run     <= '0;
            fcnt    <= '0;
        end else begin
            prev_b  <= bclk_out;
            prev_lr <= lrclk_out;
            if (bclk_out != prev_b) run <= 4'd1;
            else if (run != 4'hF)   run <= run + 4'd1;
            if (lr_chg) begin
                seen <= 1'b1;
                fcnt <= '0;
            end else if (prev_b && !bclk_out) begin
                fcnt <= fcnt + 8'd1;
            end
        end
    end

    // R3: data moves only with a generated bit-clock falling edge
    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && $stable(master_sel) && !$stable(sdata)) |-> $fell(bclk_out));

    // R4: frame clock moves only with a generated bit-clock falling edge
    a_r4_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && $stable(master_sel) && !$stable(lrclk_out)) |-> $fell(bclk_out));

    // R4: no bit-clock level lasts longer than the longest half period
    a_r4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel |-> (run <= 4'(MAX_HALF_CYC)));

    // R4: one half-frame spans exactly SLOT_W bit-clock falling edges
    a_r4_half_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && seen && lr_chg) |-> (fcnt == 8'(SLOT_W - 1)));

endmodule

bind audio_tx_port audio_tx_port_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .sdata      (sdata),
    .bclk_out   (bclk_out),
    .lrclk_out  (lrclk_out)
);

// File: tb/tb_audio_tx_port.sv
module tb_audio_tx_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_sel = 1'b1;
    logic        fmt_i2s = 1'b0;
    logic [1:0]  ratio_sel = 2'b00;
    logic        load = 1'b0;
    logic [23:0] left_in = '0;
    logic [23:0] right_in = '0;
    logic        bclk_in = 1'b1;
    logic        lrclk_in = 1'b0;
    logic        sdata, bclk_out, lrclk_out;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          mcmp = 1'b0;
    bit          done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    audio_tx_port dut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .fmt_i2s(fmt_i2s),
        .ratio_sel(ratio_sel), .load(load), .left_in(left_in), .right_in(right_in),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .sdata(sdata),
        .bclk_out(bclk_out), .lrclk_out(lrclk_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic expbit(input logic [23:0] w, input int slot, input logic i2s);
        int p = slot - (i2s ? 1 : 0);
        if (p >= 0 && p < 24) return w[23 - p];
        return 1'b0;
    endfunction

    function automatic int ratio_cycles(input logic [1:0] r);
        case (r)
            2'b00: return 4;
            2'b01: return 2;
            2'b10: return 8;
            default: return 6;
        endcase
    endfunction

    task automatic new_data();
        seed     = seed * 32'd1664525 + 32'd1013904223;
        left_in  = seed[31:8];
        seed     = seed * 32'd1664525 + 32'd1013904223;
        right_in = seed[31:8];
    endtask

    // behavioural reference for clock-master mode
    int          mk, mslot;
    logic        mb, mlr, msd;
    logic [23:0] mhl, mhr, mpl, mpr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mk = 0; mslot = 63; mb = 0; mlr = 0; msd = 0;
            mhl = '0; mhr = '0; mpl = '0; mpr = '0;
        end else if (master_sel) begin
            int cpb;
            cpb = ratio_cycles(ratio_sel);
            mk++;
            if (mk % cpb == 0) begin
                mslot = (mslot + 1) % 64;
                if (mslot == 0) begin mpl = mhl; mpr = mhr; end
                msd = expbit(mslot < 32 ? mpl : mpr, mslot % 32, fmt_i2s);
                mlr = logic'(mslot < 32) ^ fmt_i2s;
            end
            mb = (mk % cpb) >= cpb / 2;
            if (load) begin mhl = left_in; mhr = right_in; end
        end
    end

    always @(negedge clk) begin
        if (mcmp) begin
            chk("R4/R5 bclk_out", 32'(bclk_out), 32'(mb));
            chk(fmt_i2s ? "R7 lrclk_out" : "R6 lrclk_out", 32'(lrclk_out), 32'(mlr));
            chk("R2/R3/R10/R11 sdata", 32'(sdata), 32'(msd));
        end
    end

    task automatic run_master(input logic f, input logic [1:0] r);
        int per;
        @(negedge clk);
        mcmp = 1'b0; rst_n = 1'b0; master_sel = 1'b1; fmt_i2s = f; ratio_sel = r;
        repeat (2) @(negedge clk);
        chk("R1 sdata in reset", 32'(sdata), 32'd0);
        rst_n = 1'b1; mcmp = 1'b1;
        per = ratio_cycles(r) * 64;
        for (int c = 0; c < 4 * per + 20; c++) begin
            int fr = c / per;
            int off = c % per;
            @(negedge clk);
            // R10: frame 2 gets no load; R11: frame 1 loads twice
            load = 1'b0;
            if ((off == 5 && fr != 2) || (off == per / 3 && fr == 1) || off == per - 1) begin
                if (!(fr == 2 && off == per - 1)) begin
                    new_data();
                    load = 1'b1;
                end
            end
        end
        @(negedge clk);
        load = 1'b0; mcmp = 1'b0;
    endtask

    task automatic run_slave(input logic f);
        int          h = 31;
        logic        last = 1'b0;
        logic [23:0] hl = '0, hr = '0, pl = '0, pr = '0;
        logic        cur = 1'b0;
        logic        lvl_left = ~f;
        @(negedge clk);
        rst_n = 1'b0; master_sel = 1'b0; fmt_i2s = f; bclk_in = 1'b1; lrclk_in = f;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 clocks quiet in slave", {30'd0, bclk_out, lrclk_out}, 32'd0);
        for (int b = 0; b < 4 + 3 * 64; b++) begin
            int   s = (b < 4) ? 40 : (b - 4) % 64;
            int   fr = (b < 4) ? -1 : (b - 4) / 64;
            logic lvl = (s < 32) ? lvl_left : ~lvl_left;
            logic lft, e;
            bclk_in = 1'b0; lrclk_in = lvl;
            if (lvl != last) h = 0; else if (h < 31) h++;
            last = lvl;
            lft  = lvl ^ f;
            if (lft && h == 0) begin pl = hl; pr = hr; end
            e = expbit(lft ? pl : pr, h, f);
            repeat (2) @(negedge clk);
            chk("R9 synchronizer depth", 32'(sdata), 32'(cur));
            @(negedge clk);
            chk("R9/R2 slave sdata", 32'(sdata), 32'(e));
            cur = e;
            @(negedge clk);
            bclk_in = 1'b1;
            // R10: frame 1 is sent without a fresh load
            if ((b == 1) || (s == 48 && fr != 1)) begin
                new_data(); load = 1'b1; hl = left_in; hr = right_in;
            end
            @(negedge clk);
            load = 1'b0;
            repeat (3) @(negedge clk);
        end
        chk("R8 clocks quiet after run", {30'd0, bclk_out, lrclk_out}, 32'd0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sdata", 32'(sdata), 32'd0);
        chk("R1 reset bclk_out", 32'(bclk_out), 32'd0);
        chk("R1 reset lrclk_out", 32'(lrclk_out), 32'd0);
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 4; r++)
                run_master(logic'(f), 2'(r));
        run_slave(1'b0);
        run_slave(1'b1);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired R1-level run hang, actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule